// File: doc/BRIEF.md
# Flash Block Erase-Verify Sequencer

This controller erases a single block of an on-chip flash array and then proves the erase by reading every word of that block back. It does this by stepping a set of array control bits through a fixed order. A write-enable bit comes first, then an erase-setup bit, then the erase pulse itself. The bits are then released in reverse order, and a verify bit is raised for the read-back. Each step is separated by its own settle time, counted in clock cycles. A request names its block with a one-hot select vector. The controller raises a watchdog-enable output for the whole operation, and it ends with a one-cycle done pulse or fail pulse.

During verify, the controller walks the block from its first word to its last. For each word it issues a dummy write of all ones to the verify address, waits, and then strobes a read. A word passes only when every bit reads back as 1. If any word fails, verify stops, the pulse is re-applied and verify runs again from the block's first word. A retry counter caps the total number of erase pulses for one request. A caller erases several blocks by sending one request per block.

Top module: `flash_erase_verify`

## Requirements
- R1: A `start` in idle whose `blk_sel` is not one-hot (no bit set, or two or more bits set) is refused. `reject` is high for exactly the cycle after `start`. `busy`, `swe_o` and `wdt_en` stay low.
- R2: A `start` that arrives while `busy` is high is ignored. `blk_en` and the running sequence are not disturbed, and `swe_o` rises only once in the whole operation.
- R3: In the cycle after a valid `start`, `busy`, `wdt_en` and `swe_o` are all high and `blk_en` equals `blk_sel`. `busy` is high exactly while `blk_en` is nonzero. `wdt_en` is always high whenever the erase bit is high.
- R4: Erase setup follows a fixed order. `esu_o` rises T_SWE cycles after `swe_o` rises. `ers_o` rises T_ESU cycles after `esu_o` rises and stays high for exactly T_ERASE cycles. `esu_o` falls T_EOFF cycles after `ers_o` falls. `ers_o` is only ever high together with `esu_o` and `swe_o`.
- R5: `ev_o` rises T_ESUOFF cycles after `esu_o` falls, and only while `swe_o` is high and `esu_o` and `ers_o` are low. The first one-cycle `vwr` comes T_EVON cycles after `ev_o` rises, and `vwdata` is 16'hFFFF whenever `vwr` is high.
- R6: After each `vwr`, T_DWAIT idle cycles pass, and then comes a one-cycle `vrd`; the first `vrd` is therefore T_DWAIT+1 cycles after its `vwr`. A word passes only if `vrdata` is 16'hFFFF. `vwr` and `vrd` occur only while `ev_o` is high.
- R7: Verify addresses are `vaddr = block_index*BLK_WORDS + offset`, where `block_index` is the position of the set bit in `blk_sel`. Each pass starts at offset 0. A passing word that is not the last is followed in the next cycle by a `vwr` at the next offset. The last word is at offset BLK_WORDS-1.
- R8: Once the last word passes, `ev_o` falls. T_EVOFF cycles later, `done` pulses for one cycle, and in that same cycle `swe_o`, `wdt_en`, `busy` and `blk_en` are all low.
- R9: A failing word ends the pass and `ev_o` falls. If fewer than MAX_RETRY erase pulses have been applied, the erase pulse is re-run from the `esu_o` step T_EVOFF cycles later. `swe_o` stays high throughout, and verify restarts at offset 0.
- R10: If the word still fails after MAX_RETRY erase pulses, `fail` pulses for one cycle with `swe_o` and `wdt_en` low. The controller never applies more than MAX_RETRY erase pulses per request.
- R11: The retry count starts again at one on every accepted request, so a request that needs exactly MAX_RETRY pulses succeeds even right after a request that used them all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, honoured only in idle |
| blk_sel | input | NBLK | One-hot block choice for the request |
| swe_o | output | 1 | Array write-enable bit |
| esu_o | output | 1 | Erase-setup bit |
| ers_o | output | 1 | Erase pulse bit |
| ev_o | output | 1 | Erase-verify bit |
| blk_en | output | NBLK | Block-select vector driven to the array |
| wdt_en | output | 1 | Watchdog enable, high for the whole operation |
| vaddr | output | AW | Verify word address |
| vwdata | output | 16 | Dummy write data (all ones) |
| vwr | output | 1 | Dummy write strobe |
| vrd | output | 1 | Verify read strobe |
| vrdata | input | 16 | Verify read data from the array |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: block erased and verified |
| fail | output | 1 | One-cycle pulse: retry limit reached |
| reject | output | 1 | One-cycle pulse: select vector refused |

## Verification
Some rules hold on every cycle, and the assertions check these. The block select is never more than one-hot, and it matches `busy`. Erase is never high without setup, write-enable and watchdog. Verify is never high together with setup or erase. Strobes appear only inside verify. A passing word that is not the last leads straight to the next dummy write, and a failing word drops the verify bit. Done and fail both leave the enables low.

Other behaviours can only be shown by the bench's scenarios. These are the exact settle-time spacings, the address range walked for a chosen block, and the count of erase pulses under a flash model that needs one, two or too many pulses. They also include refusal of zero-bit and two-bit selects, the ignored mid-run request, and the reset of the retry count between requests.

// File: rtl/fev_pkg.sv
package fev_pkg;
  localparam int FEV_WORD_W = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_SWE, S_ESU, S_ERS, S_EOFF, S_ESUOFF,
    S_EVON, S_DWR, S_DWAIT, S_READ, S_EVOFF
  } fev_state_e;

  // A state that must last c cycles loads c-1 into the down-counter.
  function automatic int unsigned cycles_to_load(input int unsigned c);
    return (c == 0) ? 0 : c - 1;
  endfunction

  // Position of the set bit in a one-hot vector (0 when none).
  function automatic int unsigned onehot_pos(input logic [31:0] v);
    int unsigned p;
    p = 0;
    for (int i = 0; i < 32; i++) if (v[i]) p = i;
    return p;
  endfunction

  function automatic logic word_erased(input logic [FEV_WORD_W-1:0] w);
    return &w;
  endfunction
endpackage

// File: rtl/fev_delay_timer.sv
module fev_delay_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/fev_addr_walker.sv
module fev_addr_walker #(
  parameter int OW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [OW-1:0] offset,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) offset <= '0;
    else if (inc)      offset <= offset + 1'b1;
  end

  assign last = (offset == {OW{1'b1}});
endmodule

// File: rtl/fev_ctrl.sv
module fev_ctrl
  import fev_pkg::*;
#(
  parameter int NBLK      = 4,
  parameter int TW        = 16,
  parameter int MAX_RETRY = 3,
  parameter int T_SWE     = 3,
  parameter int T_ESU     = 4,
  parameter int T_ERASE   = 20,
  parameter int T_EOFF    = 2,
  parameter int T_ESUOFF  = 3,
  parameter int T_EVON    = 2,
  parameter int T_DWAIT   = 2,
  parameter int T_EVOFF   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NBLK-1:0] blk_sel,
  input  logic            tmr_zero,
  input  logic            word_ok,
  input  logic            word_last,
  output logic            tmr_ld,
  output logic [TW-1:0]   tmr_val,
  output logic            addr_clr,
  output logic            addr_inc,
  output logic            swe,
  output logic            esu,
  output logic            ers,
  output logic            ev,
  output logic            wdt,
  output logic [NBLK-1:0] sel,
  output logic            busy,
  output logic            done,
  output logic            fail,
  output logic            reject,
  output logic            vwr,
  output logic            vrd
);
  localparam int RW = $clog2(MAX_RETRY + 1) + 1;
  localparam logic [RW-1:0] N_LIM  = RW'(MAX_RETRY);
  localparam logic [TW-1:0] L_SWE  = TW'(cycles_to_load(T_SWE));
  localparam logic [TW-1:0] L_ESU  = TW'(cycles_to_load(T_ESU));
  localparam logic [TW-1:0] L_ERS  = TW'(cycles_to_load(T_ERASE));
  localparam logic [TW-1:0] L_EOFF = TW'(cycles_to_load(T_EOFF));
  localparam logic [TW-1:0] L_SOFF = TW'(cycles_to_load(T_ESUOFF));
  localparam logic [TW-1:0] L_EVON = TW'(cycles_to_load(T_EVON));
  localparam logic [TW-1:0] L_DWT  = TW'(cycles_to_load(T_DWAIT));
  localparam logic [TW-1:0] L_EVOF = TW'(cycles_to_load(T_EVOFF));

  fev_state_e st_q, st_d;
  logic swe_d, esu_d, ers_d, ev_d, wdt_d, pass_q, pass_d;
  logic done_d, fail_d, rej_d;
  logic [NBLK-1:0] sel_d;
  logic [RW-1:0] n_q, n_d;

  always_comb begin
    st_d = st_q; swe_d = swe; esu_d = esu; ers_d = ers; ev_d = ev; wdt_d = wdt;
    sel_d = sel; n_d = n_q; pass_d = pass_q;
    done_d = 1'b0; fail_d = 1'b0; rej_d = 1'b0;
    tmr_ld = 1'b0; tmr_val = '0; addr_clr = 1'b0; addr_inc = 1'b0;
    unique case (st_q)
      S_IDLE: if (start) begin
        if ($onehot(blk_sel)) begin
          st_d = S_SWE; swe_d = 1'b1; wdt_d = 1'b1; sel_d = blk_sel;
          n_d = RW'(1); tmr_ld = 1'b1; tmr_val = L_SWE;
        end else rej_d = 1'b1;
      end
      S_SWE: if (tmr_zero) begin
        st_d = S_ESU; esu_d = 1'b1; tmr_ld = 1'b1; tmr_val = L_ESU;
      end
      S_ESU: if (tmr_zero) begin
        st_d = S_ERS; ers_d = 1'b1; tmr_ld = 1'b1; tmr_val = L_ERS;
      end
      S_ERS: if (tmr_zero) begin
        st_d = S_EOFF; ers_d = 1'b0; tmr_ld = 1'b1; tmr_val = L_EOFF;
      end
      S_EOFF: if (tmr_zero) begin
        st_d = S_ESUOFF; esu_d = 1'b0; tmr_ld = 1'b1; tmr_val = L_SOFF;
      end
      S_ESUOFF: if (tmr_zero) begin
        st_d = S_EVON; ev_d = 1'b1; addr_clr = 1'b1;
        tmr_ld = 1'b1; tmr_val = L_EVON;
      end
      S_EVON:  if (tmr_zero) st_d = S_DWR;
      S_DWR: begin
        st_d = S_DWAIT; tmr_ld = 1'b1; tmr_val = L_DWT;
      end
      S_DWAIT: if (tmr_zero) st_d = S_READ;
      S_READ: begin
        if (word_ok && !word_last) begin
          addr_inc = 1'b1; st_d = S_DWR;
        end else begin
          ev_d = 1'b0; pass_d = word_ok; st_d = S_EVOFF;
          tmr_ld = 1'b1; tmr_val = L_EVOF;
        end
      end
      S_EVOFF: if (tmr_zero) begin
        if (pass_q) begin
          st_d = S_IDLE; swe_d = 1'b0; wdt_d = 1'b0; sel_d = '0; done_d = 1'b1;
        end else if (n_q < N_LIM) begin
          n_d = n_q + 1'b1; st_d = S_ESU; esu_d = 1'b1;
          tmr_ld = 1'b1; tmr_val = L_ESU;
        end else begin
          st_d = S_IDLE; swe_d = 1'b0; wdt_d = 1'b0; sel_d = '0; fail_d = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; swe <= 1'b0; esu <= 1'b0; ers <= 1'b0; ev <= 1'b0;
      wdt <= 1'b0; sel <= '0; n_q <= '0; pass_q <= 1'b0;
      done <= 1'b0; fail <= 1'b0; reject <= 1'b0;
    end else begin
      st_q <= st_d; swe <= swe_d; esu <= esu_d; ers <= ers_d; ev <= ev_d;
      wdt <= wdt_d; sel <= sel_d; n_q <= n_d; pass_q <= pass_d;
      done <= done_d; fail <= fail_d; reject <= rej_d;
    end
  end

  assign busy = (st_q != S_IDLE);
  assign vwr  = (st_q == S_DWR);
  assign vrd  = (st_q == S_READ);
endmodule

// File: rtl/flash_erase_verify.sv
module flash_erase_verify
  import fev_pkg::*;
#(
  parameter int NBLK      = 4,
  parameter int OW        = 3,
  parameter int TW        = 16,
  parameter int MAX_RETRY = 3,
  parameter int T_SWE     = 3,
  parameter int T_ESU     = 4,
  parameter int T_ERASE   = 20,
  parameter int T_EOFF    = 2,
  parameter int T_ESUOFF  = 3,
  parameter int T_EVON    = 2,
  parameter int T_DWAIT   = 2,
  parameter int T_EVOFF   = 3,
  localparam int BIW      = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int AW       = BIW + OW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [NBLK-1:0]       blk_sel,
  output logic                  swe_o,
  output logic                  esu_o,
  output logic                  ers_o,
  output logic                  ev_o,
  output logic [NBLK-1:0]       blk_en,
  output logic                  wdt_en,
  output logic [AW-1:0]         vaddr,
  output logic [FEV_WORD_W-1:0] vwdata,
  output logic                  vwr,
  output logic                  vrd,
  input  logic [FEV_WORD_W-1:0] vrdata,
  output logic                  busy,
  output logic                  done,
  output logic                  fail,
  output logic                  reject
);
  // Internal events, named for the bound checker.
  logic          tmr_zero, tmr_ld, addr_clr, addr_inc, word_ok, word_last;
  logic [TW-1:0] tmr_val;
  logic [OW-1:0] offset;

  assign word_ok = word_erased(vrdata);

  fev_delay_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_ld), .load_val(tmr_val), .expired(tmr_zero)
  );

  fev_addr_walker #(.OW(OW)) u_walk (
    .clk(clk), .rst_n(rst_n), .clr(addr_clr), .inc(addr_inc),
    .offset(offset), .last(word_last)
  );

  fev_ctrl #(
    .NBLK(NBLK), .TW(TW), .MAX_RETRY(MAX_RETRY), .T_SWE(T_SWE), .T_ESU(T_ESU),
    .T_ERASE(T_ERASE), .T_EOFF(T_EOFF), .T_ESUOFF(T_ESUOFF), .T_EVON(T_EVON),
    .T_DWAIT(T_DWAIT), .T_EVOFF(T_EVOFF)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_sel(blk_sel),
    .tmr_zero(tmr_zero), .word_ok(word_ok), .word_last(word_last),
    .tmr_ld(tmr_ld), .tmr_val(tmr_val), .addr_clr(addr_clr), .addr_inc(addr_inc),
    .swe(swe_o), .esu(esu_o), .ers(ers_o), .ev(ev_o), .wdt(wdt_en), .sel(blk_en),
    .busy(busy), .done(done), .fail(fail), .reject(reject), .vwr(vwr), .vrd(vrd)
  );

  assign vaddr  = {BIW'(onehot_pos(32'(blk_en))), offset};
  assign vwdata = {FEV_WORD_W{1'b1}};
endmodule

// File: rtl/flash_erase_verify_chk.sv
module flash_erase_verify_chk #(
  parameter int NBLK = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            swe_o,
  input logic            esu_o,
  input logic            ers_o,
  input logic            ev_o,
  input logic            wdt_en,
  input logic [NBLK-1:0] blk_en,
  input logic            vwr,
  input logic            vrd,
  input logic            done,
  input logic            fail,
  input logic            reject,
  input logic            tmr_zero,
  input logic            word_ok,
  input logic            word_last
);
  p_reject_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (!busy && !swe_o && !wdt_en));

  p_sel_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(blk_en));

  p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(blk_en) && (busy == (blk_en != '0)));

  p_erase_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ers_o |-> (esu_o && swe_o && wdt_en && !ev_o));

  p_setup_needs_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    esu_o |-> swe_o);

  p_erase_ends_timed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ers_o) |-> $past(tmr_zero));

  p_verify_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_o |-> (swe_o && !esu_o && !ers_o));

  p_strobe_in_verify_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vwr || vrd) |-> ev_o);

  p_bad_word_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd && !word_ok) |=> !ev_o);

  p_next_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd && word_ok && !word_last) |=> vwr);

  p_done_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!swe_o && !wdt_en && !busy && !fail));

  p_fail_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!swe_o && !wdt_en && !busy));
endmodule

bind flash_erase_verify flash_erase_verify_chk #(.NBLK(NBLK)) u_chk (.*);

// File: tb/flash_erase_verify_bench.sv
module flash_erase_verify_bench;
  localparam int NBLK = 4, OW = 3, AW = 5, BW = 8, MAXR = 3;
  localparam int T_SWE = 3, T_ESU = 4, T_ERASE = 20, T_EOFF = 2;
  localparam int T_ESUOFF = 3, T_EVON = 2, T_DWAIT = 2, T_EVOFF = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [NBLK-1:0] blk_sel = '0;
  logic swe_o, esu_o, ers_o, ev_o, wdt_en, vwr, vrd, busy, done, fail, reject;
  logic [NBLK-1:0] blk_en;
  logic [AW-1:0] vaddr;
  logic [15:0] vwdata, vrdata;

  always #10 clk = ~clk;

  flash_erase_verify #(
    .NBLK(NBLK), .OW(OW), .TW(16), .MAX_RETRY(MAXR), .T_SWE(T_SWE), .T_ESU(T_ESU),
    .T_ERASE(T_ERASE), .T_EOFF(T_EOFF), .T_ESUOFF(T_ESUOFF), .T_EVON(T_EVON),
    .T_DWAIT(T_DWAIT), .T_EVOFF(T_EVOFF)
  ) u_flash_erase_verify (.*);

  int tests = 0, fails = 0;
  int cyc = 0;
  int t_swe_r, t_esu_r, t_esu_f, t_ers_r, t_ers_f, t_ev_r, t_ev_f, t_wr, t_rd, t_end;
  int n_ers, n_swe_r, n_rd, n_done, n_fail, bad_guard;
  int need = 1, bad_off = 0;
  logic [AW-1:0] first_addr, last_addr;
  logic p_swe = 0, p_esu = 0, p_ers = 0, p_ev = 0;

  // Flash model: the word at bad_off stays unerased until 'need' pulses are applied.
  assign vrdata = ((n_ers >= need) || (vaddr[OW-1:0] != bad_off[OW-1:0])) ? 16'hFFFF : 16'hFFFE;

  task automatic clear_log();
    t_swe_r = -1; t_esu_r = -1; t_esu_f = -1; t_ers_r = -1; t_ers_f = -1;
    t_ev_r = -1; t_ev_f = -1; t_wr = -1; t_rd = -1; t_end = -1;
    n_ers = 0; n_swe_r = 0; n_rd = 0; n_done = 0; n_fail = 0; bad_guard = 0;
    first_addr = '0; last_addr = '0;
  endtask

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (swe_o && !p_swe) begin n_swe_r++; if (t_swe_r < 0) t_swe_r = cyc; end
    if (esu_o && !p_esu && t_esu_r < 0) t_esu_r = cyc;
    if (!esu_o && p_esu && t_esu_f < 0) t_esu_f = cyc;
    if (ers_o && !p_ers) begin
      n_ers++; if (t_ers_r < 0) t_ers_r = cyc;
      if (!wdt_en) bad_guard++;
    end
    if (!ers_o && p_ers && t_ers_f < 0) t_ers_f = cyc;
    if (ev_o && !p_ev && t_ev_r < 0) t_ev_r = cyc;
    if (!ev_o && p_ev) t_ev_f = cyc;
    if (vwr) begin
      if (t_wr < 0) t_wr = cyc;
      if (vwdata != 16'hFFFF) bad_guard++;
    end
    if (vrd) begin
      if (t_rd < 0) begin t_rd = cyc; first_addr = vaddr; end
      n_rd++; last_addr = vaddr;
    end
    if (done) begin n_done++; t_end = cyc; end
    if (fail) begin n_fail++; t_end = cyc; end
    p_swe = swe_o; p_esu = esu_o; p_ers = ers_o; p_ev = ev_o;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [NBLK-1:0] s);
    blk_sel = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    int k = 0;
    while (n_done + n_fail == 0 && k < 5000) begin @(negedge clk); k++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy && !swe_o && !wdt_en && blk_en == 0 && !ers_o && !ev_o, "R3", "idle after reset", int'(busy), 0);
  endtask

  task automatic t_reject(input logic [NBLK-1:0] s);
    clear_log();
    pulse_start(s);
    chk(reject == 1'b1, "R1", "reject pulse", int'(reject), 1);
    chk(!busy && !swe_o && !wdt_en, "R1", "stays idle", int'(busy), 0);
    @(negedge clk);
    chk(reject == 1'b0, "R1", "reject one cycle", int'(reject), 0);
  endtask

  task automatic t_pass(input int idx);
    logic [NBLK-1:0] s;
    s = NBLK'(1) << idx;
    clear_log(); need = 1; bad_off = 0;
    pulse_start(s);
    chk(busy && wdt_en && swe_o && blk_en == s, "R3", "accept state", int'(blk_en), int'(s));
    repeat (10) @(negedge clk);
    pulse_start(~s & 4'b0001 | (s == 4'b0001 ? 4'b0010 : 4'b0000));
    chk(blk_en == s, "R2", "blk_en after busy start", int'(blk_en), int'(s));
    wait_end();
    chk(t_esu_r - t_swe_r == T_SWE, "R4", "swe->esu", t_esu_r - t_swe_r, T_SWE);
    chk(t_ers_r - t_esu_r == T_ESU, "R4", "esu->ers", t_ers_r - t_esu_r, T_ESU);
    chk(t_ers_f - t_ers_r == T_ERASE, "R4", "erase width", t_ers_f - t_ers_r, T_ERASE);
    chk(t_esu_f - t_ers_f == T_EOFF, "R4", "ers off->esu off", t_esu_f - t_ers_f, T_EOFF);
    chk(t_ev_r - t_esu_f == T_ESUOFF, "R5", "esu off->ev", t_ev_r - t_esu_f, T_ESUOFF);
    chk(t_wr - t_ev_r == T_EVON, "R5", "ev->first write", t_wr - t_ev_r, T_EVON);
    chk(bad_guard == 0, "R5", "write data / watchdog guard", bad_guard, 0);
    chk(t_rd - t_wr == T_DWAIT + 1, "R6", "write->read", t_rd - t_wr, T_DWAIT + 1);
    chk(int'(first_addr) == idx * BW, "R7", "first address", int'(first_addr), idx * BW);
    chk(int'(last_addr) == idx * BW + BW - 1, "R7", "last address", int'(last_addr), idx * BW + BW - 1);
    chk(n_rd == BW, "R7", "words read", n_rd, BW);
    chk(n_swe_r == 1, "R2", "single swe rise", n_swe_r, 1);
    chk(n_done == 1 && n_fail == 0, "R8", "done pulse", n_done, 1);
    chk(t_end - t_ev_f == T_EVOFF, "R8", "ev off->done", t_end - t_ev_f, T_EVOFF);
    chk(!swe_o && !wdt_en && !busy && blk_en == 0, "R8", "released", int'(swe_o), 0);
  endtask

  task automatic t_retry(input int idx, input int nd, input int bo, input string req);
    clear_log(); need = nd; bad_off = bo;
    pulse_start(NBLK'(1) << idx);
    wait_end();
    chk(n_ers == nd, req, "erase pulses", n_ers, nd);
    chk(n_rd == (nd - 1) * (bo + 1) + BW, req, "words read", n_rd, (nd - 1) * (bo + 1) + BW);
    chk(n_done == 1 && n_fail == 0, req, "done after retries", n_done, 1);
    chk(n_swe_r == 1, "R9", "swe held over retry", n_swe_r, 1);
    chk(int'(last_addr) == idx * BW + BW - 1, "R9", "verify restarts and completes", int'(last_addr), idx * BW + BW - 1);
  endtask

  task automatic t_limit(input int idx, input int bo);
    clear_log(); need = 99; bad_off = bo;
    pulse_start(NBLK'(1) << idx);
    wait_end();
    chk(n_ers == MAXR, "R10", "pulse cap", n_ers, MAXR);
    chk(n_fail == 1 && n_done == 0, "R10", "fail pulse", n_fail, 1);
    chk(n_rd == MAXR * (bo + 1), "R10", "words read", n_rd, MAXR * (bo + 1));
    chk(t_end - t_ev_f == T_EVOFF, "R10", "ev off->fail", t_end - t_ev_f, T_EVOFF);
    chk(!swe_o && !wdt_en && !busy, "R10", "released", int'(swe_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clear_log();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reject(4'b0000);
    t_reject(4'b0101);
    t_pass(0);
    t_pass(2);
    t_retry(1, 2, 5, "R9");
    t_limit(3, 7);
    t_retry(2, MAXR, 0, "R11");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule